// File: doc/BRIEF.md
# Character LCD Parallel Bus Controller

This block drives an 8-bit character LCD over its parallel bus. It controls a register-select line, a read/write line, an enable strobe and a split data bus: a byte output, an output enable and the sampled top data bit. Before every write it reads the panel's status repeatedly and waits until the busy bit (data bit 7) reads clear. Only then does it place the byte on the bus and strobe the enable line. The enable high time, the read sample point, the minimum enable low time, the setup time and the hold time are all clock-count parameters.

Right after reset the controller sends a fixed four-command power-up program on its own: 8-bit two-line mode, display and cursor on, entry mode increment, then clear. While this runs, the client's `req_ready` stays low. After that, a client issues single command or character writes with a valid/ready handshake. The client can also fill a small local buffer and start a string. A string writes a line-address command first, then the buffer's characters in order up to the first zero byte.

A poll limit guards against a panel that never becomes ready. If every status read in the limit returns busy, the controller drops the transfer, pulses an error output and returns to idle.

Top module: `charlcd_ctrl`

## Requirements
- R1: In reset and whenever `req_ready` is high, `lcd_e` is 0, `lcd_rw` is 1 and `lcd_db_oe` is 0; `req_ready` is 0 during reset.
- R2: Every transfer starts with status reads: `lcd_rs`=0, `lcd_rw`=1, bus output disabled, and `lcd_e` pulses. Pulses repeat while the sampled bit reads 1. The write starts only after a read returns 0, so N busy reads give N+1 read pulses.
- R3: Each `lcd_e` pulse is high for exactly E_HIGH cycles, and `lcd_e` has been low for at least E_LOW cycles before each rise. The busy bit is sampled in the RD_DLY-th high cycle of a read pulse, and at no other time.
- R4: A command write drives `lcd_rs`=0 and `lcd_rw`=0 and enables the bus output. The byte is held stable, and the bus stays enabled, from before the `lcd_e` rise until after its fall. The output enable is never on while `lcd_rw` is 1.
- R5: A character write is identical to a command write except that `lcd_rs`=1.
- R6: After reset the commands 0x38, 0x0F, 0x06, 0x01 are written in this order with `lcd_rs`=0. `req_ready` stays 0 until the fourth of them has been written.
- R7: A request with `req_valid` and `req_ready` both high in a cycle is accepted. It produces exactly one write with `req_rs` as `lcd_rs` and `req_byte` as data. `req_ready` is 0 from the next cycle until that transfer ends.
- R8: A `str_start` accepted while ready first writes the line command: 0x80 when `str_line`=0, 0xC0 when `str_line`=1. It then writes buffer entries 0, 1, 2, … as characters and stops before the first zero entry, which is not sent, or after all BUF_DEPTH entries.
- R9: If TMO_POLLS status reads in a row return busy, `busy_tmo` pulses for one cycle and no write occurs for that transfer. Any rest of a running string is dropped, and `req_ready` returns high. If the TMO_POLLS-th read returns not busy, the write proceeds.
- R10: When `req_valid` and `str_start` are both high in a ready cycle, the client request is served and `str_start` is ignored: no line command or string write follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client write request valid |
| req_rs | input | 1 | Request kind: 0 command, 1 character |
| req_byte | input | 8 | Request byte |
| req_ready | output | 1 | Controller can accept a request or string start |
| buf_we | input | 1 | String buffer write enable |
| buf_waddr | input | $clog2(BUF_DEPTH) | String buffer write address |
| buf_wdata | input | 8 | String buffer write data |
| str_start | input | 1 | Start string output (taken only when ready) |
| str_line | input | 1 | Display line for the string: 0 first, 1 second |
| lcd_rs | output | 1 | Panel register select |
| lcd_rw | output | 1 | Panel read (1) / write (0) |
| lcd_e | output | 1 | Panel enable strobe |
| lcd_db_out | output | 8 | Data bus output byte (0xFF when not driving) |
| lcd_db_oe | output | 1 | Data bus output enable |
| lcd_db7_in | input | 1 | Sampled data bus bit 7 (busy flag) |
| busy_tmo | output | 1 | One-cycle pulse: transfer dropped on busy timeout |

## Verification
The bench's panel model drives the busy bit correctly only in the RD_DLY-th enable-high cycle and drives the opposite value at all other times. A controller that samples early, late or with enable low therefore gets the poll count wrong or writes while the panel is busy. Busy runs of exactly TMO_POLLS-1 and TMO_POLLS separate an off-by-one timeout: one design would drop a write it should make, the other would write into a busy panel. Strings are checked at both ends: a zero in the middle must stop output with the zero itself unsent, and a buffer with no zero must end after the last entry instead of wrapping. A simultaneous client request and string start exposes wrong priority as an extra line command.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  localparam int INIT_LEN = 4;

  typedef enum logic [2:0] {
    EN_IDLE, EN_P_SET, EN_P_HI, EN_P_LO, EN_W_SET, EN_W_HI, EN_W_HOLD
  } eng_st_t;

  typedef enum logic [2:0] {
    SQ_INIT, SQ_INIT_W, SQ_IDLE, SQ_CLI_W, SQ_STR_W, SQ_STR_NEXT
  } seq_st_t;

  // power-up program, issued in index order
  function automatic logic [7:0] init_cmd(input logic [1:0] idx);
    case (idx)
      2'd0:    return 8'h38;
      2'd1:    return 8'h0F;
      2'd2:    return 8'h06;
      default: return 8'h01;
    endcase
  endfunction

  // set-address command for the start of a display line
  function automatic logic [7:0] line_cmd(input logic line);
    return line ? 8'hC0 : 8'h80;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lcd_strbuf.sv
module lcd_strbuf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem[g] <= 8'h00;
      else if (we && waddr == AW'(g))      mem[g] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine import lcd_pkg::*; #(
  parameter int E_HIGH    = 4,
  parameter int RD_DLY    = 3,
  parameter int E_LOW     = 3,
  parameter int T_SETUP   = 2,
  parameter int T_HOLD    = 2,
  parameter int TMO_POLLS = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       go_rs,
  input  logic [7:0] go_byte,
  output logic       idle,
  output logic       done,
  output logic       tmo,
  output logic       smp_stb,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic       db7_in
);

  // write hold also serves as the enable-low gap before the next transfer
  localparam int W_END   = max2(T_HOLD, E_LOW);
  localparam int CNT_MAX = max2(max2(E_HIGH, E_LOW), max2(T_SETUP, W_END));
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int PW      = $clog2(TMO_POLLS + 1);

  eng_st_t       st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] polls;
  logic          busy_q;
  logic          rs_q;
  logic [7:0]    byte_q;
  logic          wr_phase;

  function automatic logic last(input logic [CW-1:0] c, input int len);
    return c == CW'(len - 1);
  endfunction

  assign wr_phase = (st == EN_W_SET) || (st == EN_W_HI) || (st == EN_W_HOLD);
  assign smp_stb  = (st == EN_P_HI) && last(cnt, RD_DLY);
  assign done     = (st == EN_W_HOLD) && last(cnt, W_END);
  assign tmo      = (st == EN_P_LO) && last(cnt, E_LOW) && busy_q &&
                    (polls == PW'(TMO_POLLS));
  assign idle     = (st == EN_IDLE);

  assign lcd_e      = (st == EN_P_HI) || (st == EN_W_HI);
  assign lcd_rw     = !wr_phase;
  assign lcd_rs     = wr_phase ? rs_q : 1'b0;
  assign lcd_db_oe  = wr_phase;
  assign lcd_db_out = wr_phase ? byte_q : 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= EN_IDLE;
      cnt    <= '0;
      polls  <= '0;
      busy_q <= 1'b0;
      rs_q   <= 1'b0;
      byte_q <= 8'h00;
    end else begin
      case (st)
        EN_IDLE: if (go) begin
          rs_q   <= go_rs;
          byte_q <= go_byte;
          polls  <= '0;
          cnt    <= '0;
          st     <= EN_P_SET;
        end
        EN_P_SET: begin
          if (last(cnt, T_SETUP)) begin cnt <= '0; st <= EN_P_HI; end
          else cnt <= cnt + 1'b1;
        end
        EN_P_HI: begin
          if (smp_stb) busy_q <= db7_in;
          if (last(cnt, E_HIGH)) begin
            cnt   <= '0;
            polls <= polls + 1'b1;
            st    <= EN_P_LO;
          end else cnt <= cnt + 1'b1;
        end
        EN_P_LO: begin
          if (last(cnt, E_LOW)) begin
            cnt <= '0;
            if (!busy_q)                         st <= EN_W_SET;
            else if (polls == PW'(TMO_POLLS))    st <= EN_IDLE;
            else                                 st <= EN_P_HI;
          end else cnt <= cnt + 1'b1;
        end
        EN_W_SET: begin
          if (last(cnt, T_SETUP)) begin cnt <= '0; st <= EN_W_HI; end
          else cnt <= cnt + 1'b1;
        end
        EN_W_HI: begin
          if (last(cnt, E_HIGH)) begin cnt <= '0; st <= EN_W_HOLD; end
          else cnt <= cnt + 1'b1;
        end
        EN_W_HOLD: begin
          if (last(cnt, W_END)) begin cnt <= '0; st <= EN_IDLE; end
          else cnt <= cnt + 1'b1;
        end
        default: st <= EN_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/charlcd_ctrl.sv
module charlcd_ctrl import lcd_pkg::*; #(
  parameter int E_HIGH    = 4,
  parameter int RD_DLY    = 3,
  parameter int E_LOW     = 3,
  parameter int T_SETUP   = 2,
  parameter int T_HOLD    = 2,
  parameter int TMO_POLLS = 20,
  parameter int BUF_DEPTH = 16,
  localparam int BAW = $clog2(BUF_DEPTH),
  localparam int SIW = $clog2(BUF_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_rs,
  input  logic [7:0]     req_byte,
  output logic           req_ready,
  input  logic           buf_we,
  input  logic [BAW-1:0] buf_waddr,
  input  logic [7:0]     buf_wdata,
  input  logic           str_start,
  input  logic           str_line,
  output logic           lcd_rs,
  output logic           lcd_rw,
  output logic           lcd_e,
  output logic [7:0]     lcd_db_out,
  output logic           lcd_db_oe,
  input  logic           lcd_db7_in,
  output logic           busy_tmo
);

  seq_st_t        sq;
  logic [1:0]     init_idx;
  logic [SIW-1:0] str_idx;
  logic [7:0]     buf_rdata;
  logic           str_end;

  logic           eng_go, eng_rs, eng_idle, eng_done, eng_tmo, eng_fin;
  logic [7:0]     eng_byte;
  logic           busy_smp_stb;   // brought out for the checker

  lcd_strbuf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (str_idx[BAW-1:0]),
    .rdata (buf_rdata)
  );

  lcd_bus_engine #(
    .E_HIGH(E_HIGH), .RD_DLY(RD_DLY), .E_LOW(E_LOW),
    .T_SETUP(T_SETUP), .T_HOLD(T_HOLD), .TMO_POLLS(TMO_POLLS)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (eng_go),
    .go_rs      (eng_rs),
    .go_byte    (eng_byte),
    .idle       (eng_idle),
    .done       (eng_done),
    .tmo        (eng_tmo),
    .smp_stb    (busy_smp_stb),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e),
    .lcd_db_out (lcd_db_out),
    .lcd_db_oe  (lcd_db_oe),
    .db7_in     (lcd_db7_in)
  );

  assign eng_fin   = eng_done || eng_tmo;
  assign busy_tmo  = eng_tmo;
  assign req_ready = (sq == SQ_IDLE) && eng_idle;
  assign str_end   = (str_idx == SIW'(BUF_DEPTH)) || (buf_rdata == 8'h00);

  always_comb begin
    eng_go   = 1'b0;
    eng_rs   = 1'b0;
    eng_byte = 8'h00;
    case (sq)
      SQ_INIT: begin
        eng_go   = 1'b1;
        eng_byte = init_cmd(init_idx);
      end
      SQ_IDLE: begin
        if (req_valid) begin
          eng_go   = 1'b1;
          eng_rs   = req_rs;
          eng_byte = req_byte;
        end else if (str_start) begin
          eng_go   = 1'b1;
          eng_byte = line_cmd(str_line);
        end
      end
      SQ_STR_NEXT: begin
        if (!str_end) begin
          eng_go   = 1'b1;
          eng_rs   = 1'b1;
          eng_byte = buf_rdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq       <= SQ_INIT;
      init_idx <= '0;
      str_idx  <= '0;
    end else begin
      case (sq)
        SQ_INIT:   sq <= SQ_INIT_W;
        SQ_INIT_W: if (eng_fin) begin
          if (init_idx == 2'(INIT_LEN - 1)) sq <= SQ_IDLE;
          else begin
            init_idx <= init_idx + 1'b1;
            sq       <= SQ_INIT;
          end
        end
        SQ_IDLE: begin
          if (req_valid) sq <= SQ_CLI_W;
          else if (str_start) begin
            str_idx <= '0;
            sq      <= SQ_STR_W;
          end
        end
        SQ_CLI_W: if (eng_fin) sq <= SQ_IDLE;
        SQ_STR_W: begin
          if (eng_tmo)       sq <= SQ_IDLE;
          else if (eng_done) sq <= SQ_STR_NEXT;
        end
        SQ_STR_NEXT: begin
          if (str_end) sq <= SQ_IDLE;
          else begin
            str_idx <= str_idx + 1'b1;
            sq      <= SQ_STR_W;
          end
        end
        default: sq <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lcd_ctrl_chk.sv
module lcd_ctrl_chk #(
  parameter int E_HIGH = 4,
  parameter int E_LOW  = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lcd_e,
  input logic       lcd_rw,
  input logic       lcd_rs,
  input logic       lcd_db_oe,
  input logic [7:0] lcd_db_out,
  input logic       req_ready,
  input logic       busy_tmo,
  input logic       smp_stb
);

  logic        e_q;
  logic [15:0] ehi_run, elo_run;
  logic [2:0]  wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q     <= 1'b0;
      ehi_run <= '0;
      elo_run <= 16'(E_LOW);
      wr_seen <= '0;
    end else begin
      e_q <= lcd_e;
      if (lcd_e) begin
        ehi_run <= (ehi_run == 16'hFFFF) ? ehi_run : ehi_run + 1'b1;
        elo_run <= '0;
      end else begin
        ehi_run <= '0;
        elo_run <= (elo_run == 16'hFFFF) ? elo_run : elo_run + 1'b1;
      end
      if (e_q && !lcd_e && !lcd_rw && wr_seen != 3'd4) wr_seen <= wr_seen + 1'b1;
    end
  end

  assert_e_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (e_q && !lcd_e) |-> (ehi_run == 16'(E_HIGH)));

  assert_e_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!e_q && lcd_e) |-> (elo_run >= 16'(E_LOW)));

  assert_sample_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (lcd_e && lcd_rw));

  assert_oe_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_db_oe |-> !lcd_rw);

  assert_wr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_db_oe && $past(lcd_db_oe)) |-> ($stable(lcd_db_out) && $stable(lcd_rs)));

  assert_oe_past_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (e_q && !lcd_e && !lcd_rw) |-> lcd_db_oe);

  assert_ready_after_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (wr_seen == 3'd4));

  assert_ready_bus_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (lcd_rw && !lcd_e && !lcd_db_oe));

  assert_tmo_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_tmo |-> (lcd_rw && !lcd_db_oe && !lcd_e));

endmodule

bind charlcd_ctrl lcd_ctrl_chk #(.E_HIGH(E_HIGH), .E_LOW(E_LOW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lcd_e      (lcd_e),
  .lcd_rw     (lcd_rw),
  .lcd_rs     (lcd_rs),
  .lcd_db_oe  (lcd_db_oe),
  .lcd_db_out (lcd_db_out),
  .req_ready  (req_ready),
  .busy_tmo   (busy_tmo),
  .smp_stb    (busy_smp_stb)
);

// File: tb/sim_charlcd_ctrl.sv
`timescale 1ns/1ps
module sim_charlcd_ctrl;

  localparam int E_HIGH = 4, RD_DLY = 3, E_LOW = 3, T_SETUP = 2, T_HOLD = 2;
  localparam int TMO = 20, DEPTH = 16, BAW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rs = 1'b0, buf_we = 1'b0, str_start = 1'b0, str_line = 1'b0;
  logic [7:0] req_byte = 8'h00, buf_wdata = 8'h00;
  logic [BAW-1:0] buf_waddr = '0;
  logic req_ready, lcd_rs, lcd_rw, lcd_e, lcd_db_oe, lcd_db7_in, busy_tmo;
  logic [7:0] lcd_db_out;

  always #2.5 clk = ~clk;

  charlcd_ctrl #(.E_HIGH(E_HIGH), .RD_DLY(RD_DLY), .E_LOW(E_LOW), .T_SETUP(T_SETUP),
                 .T_HOLD(T_HOLD), .TMO_POLLS(TMO), .BUF_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rs(req_rs), .req_byte(req_byte),
    .req_ready(req_ready), .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .str_start(str_start), .str_line(str_line), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_e(lcd_e), .lcd_db_out(lcd_db_out), .lcd_db_oe(lcd_db_oe),
    .lcd_db7_in(lcd_db7_in), .busy_tmo(busy_tmo));

  int total = 0, bad = 0;

  // panel model state
  int busy_left = 2, reload = 1, ehi_cnt = 0, polls = 0, cap_n = 0, tmo_n = 0;
  logic e_prev = 1'b0;
  logic       cap_rs  [0:511];
  logic [7:0] cap_b   [0:511];
  logic       cap_rdy [0:511];
  logic [7:0] sbuf [0:DEPTH-1];

  // busy bit is truthful only in the RD_DLY-th high cycle of a read strobe
  assign lcd_db7_in = (lcd_e && lcd_rw && ehi_cnt == RD_DLY) ? (busy_left > 0) : !(busy_left > 0);

  always @(negedge clk) begin
    if (rst_n) begin
      if (lcd_e) ehi_cnt = ehi_cnt + 1; else ehi_cnt = 0;
      if (e_prev && !lcd_e) begin
        if (lcd_rw) begin
          polls = polls + 1;
          if (busy_left > 0) busy_left = busy_left - 1;
        end else if (cap_n < 512) begin
          cap_rs[cap_n]  = lcd_rs;
          cap_b[cap_n]   = lcd_db_out;
          cap_rdy[cap_n] = req_ready;
          cap_n = cap_n + 1;
          busy_left = reload;
        end
      end
      if (busy_tmo) tmo_n = tmo_n + 1;
      e_prev = lcd_e;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_polls(input int nb);
    return (nb < TMO) ? nb + 1 : TMO;
  endfunction

  function automatic logic [7:0] exp_line(input logic ln);
    return 8'h80 | (ln ? 8'h40 : 8'h00);
  endfunction

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic idle_check(input string tag);
    chk(lcd_rw === 1'b1 && lcd_e === 1'b0 && lcd_db_oe === 1'b0, tag,
        {lcd_rw, lcd_e, lcd_db_oe}, 3'b100);
  endtask

  task automatic client(input logic rs, input logic [7:0] b, input int nb);
    int c0, p0, t0;
    wait_ready();
    busy_left = nb; reload = 0;
    c0 = cap_n; p0 = polls; t0 = tmo_n;
    req_valid = 1'b1; req_rs = rs; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R7 ready low after accept", req_ready, 0);
    wait_ready();
    chk(polls - p0 == exp_polls(nb), "R2 read pulse count", polls - p0, exp_polls(nb));
    if (nb < TMO) begin
      chk(cap_n == c0 + 1, "R7 one write per request", cap_n - c0, 1);
      if (cap_n == c0 + 1) begin
        chk(cap_rs[c0] == rs, rs ? "R5 data rs" : "R4 command rs", cap_rs[c0], rs);
        chk(cap_b[c0] == b, "R7 written byte", cap_b[c0], b);
      end
      chk(tmo_n == t0, "R9 no timeout", tmo_n - t0, 0);
    end else begin
      chk(cap_n == c0, "R9 no write on timeout", cap_n - c0, 0);
      chk(tmo_n == t0 + 1, "R9 one timeout pulse", tmo_n - t0, 1);
    end
    idle_check("R1 idle bus");
  endtask

  task automatic load_buf(input int zpos);
    for (int i = 0; i < DEPTH; i++) begin
      sbuf[i] = (i == zpos) ? 8'h00 : 8'($urandom_range(1, 255));
      buf_we = 1'b1; buf_waddr = BAW'(i); buf_wdata = sbuf[i];
      @(negedge clk);
    end
    buf_we = 1'b0;
  endtask

  task automatic run_string(input logic ln, input int nb);
    int c0, t0, n;
    n = 0;
    while (n < DEPTH && sbuf[n] != 8'h00) n++;
    wait_ready();
    busy_left = nb; reload = 0;
    c0 = cap_n; t0 = tmo_n;
    str_start = 1'b1; str_line = ln;
    @(negedge clk);
    str_start = 1'b0;
    wait_ready();
    if (nb >= TMO) begin
      chk(cap_n == c0, "R9 string dropped", cap_n - c0, 0);
      chk(tmo_n == t0 + 1, "R9 string timeout pulse", tmo_n - t0, 1);
    end else begin
      chk(cap_n == c0 + 1 + n, "R8 string length", cap_n - c0, n + 1);
      chk(cap_rs[c0] == 1'b0 && cap_b[c0] == exp_line(ln), "R8 line command",
          cap_b[c0], exp_line(ln));
      for (int i = 0; i < n && c0 + 1 + i < cap_n; i++)
        chk(cap_rs[c0+1+i] == 1'b1 && cap_b[c0+1+i] == sbuf[i], "R8 string char",
            cap_b[c0+1+i], sbuf[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c0, dummy;
    dummy = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lcd_e === 1'b0 && lcd_rw === 1'b1 && lcd_db_oe === 1'b0, "R1 reset bus",
        {lcd_e, lcd_rw, lcd_db_oe}, 3'b010);
    chk(req_ready === 1'b0, "R1 ready low in reset", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0, "R6 ready low while starting", req_ready, 0);
    wait_ready();
    // R6 power-up program: 2 busy then 1 busy per command
    chk(cap_n == 4, "R6 init write count", cap_n, 4);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] e;
      e = (i == 0) ? 8'h38 : (i == 1) ? 8'h0F : (i == 2) ? 8'h06 : 8'h01;
      chk(cap_b[i] == e && cap_rs[i] == 1'b0, "R6 init command", cap_b[i], e);
      chk(cap_rdy[i] == 1'b0, "R6 ready held low", cap_rdy[i], 0);
    end
    chk(polls == 9, "R2 init read pulses", polls, 9);
    idle_check("R1 idle after init");

    // directed corners
    client(1'b0, 8'h80, 0);
    client(1'b1, 8'h41, 1);
    client(1'b0, 8'hC0, TMO - 1);   // R9 last allowed read clears
    client(1'b1, 8'h5A, TMO);       // R9 timeout
    client(1'b1, 8'hFF, 0);

    // random mix
    for (int k = 0; k < 40; k++)
      client(1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)), $urandom_range(0, 6));

    // R8 strings: zero mid buffer, zero at entry 0, no zero at all
    load_buf(5);  run_string(1'b1, 0);
    load_buf(9);  run_string(1'b0, 2);
    load_buf(0);  run_string(1'b1, 0);
    load_buf(-1); run_string(1'b0, 1);
    load_buf(3);  run_string(1'b1, TMO);  // R9 string abandoned

    // R10 client wins over string start
    wait_ready();
    busy_left = 0; reload = 0; c0 = cap_n;
    req_valid = 1'b1; req_rs = 1'b1; req_byte = 8'h33; str_start = 1'b1; str_line = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; str_start = 1'b0;
    wait_ready();
    repeat (60) @(negedge clk);
    chk(cap_n == c0 + 1, "R10 only client write", cap_n - c0, 1);
    chk(cap_b[c0] == 8'h33, "R10 client byte", cap_b[c0], 8'h33);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule